// File: doc/BRIEF.md
# Increment-and-Skip Instruction Executor

This block runs two single-word instructions of a small 8-bit accumulator-style core. Both add one to a byte held in a banked data memory. One skips the following instruction when the new value is zero. The other skips it when the new value is not zero. The result goes either to the working register (W) or back to the memory byte it came from.

Each instruction cycle takes four clock phases, in this order: decode, read the operand, form the sum, write the destination. When a skip is taken, the instruction that was already fetched is thrown away and idle cycles run in its place: one cycle for a one-word instruction, two for a two-word one.

The host starts an instruction with a one-clock strobe while `ready_o` is high. It then waits for `done_o`. At that point it reads back the skip request, the cycle count and the program-counter step. Memory contents are loaded through a simple write port. Any byte can be read back combinationally through a peek port.

Top module: `incskip_exec`

## Requirements
- R1: Instruction fields: bits [15:10] hold the opcode, bit 9 selects the destination, bit 8 selects the banking mode, and bits [7:0] hold the register address. Opcode 6'b001111 is the skip-on-zero variant. Opcode 6'b010010 is the skip-on-nonzero variant.
- R2: The new value is the operand plus one, modulo 256, so 8'hFF becomes 8'h00.
- R3: When bit 9 is 0, the new value goes to W and memory is left unchanged. When bit 9 is 1, the new value is written back to the addressed byte and W is left unchanged.
- R4: When bit 8 is 0, the bank input has no effect. Addresses 8'h00–8'h7F select bank 0. Addresses 8'h80–8'hFF select bank 15. The full address is {bank, address}.
- R5: When bit 8 is 1, the full memory address is {bank_i, instr[7:0]}.
- R6: The skip-on-zero variant asserts `skip_o` exactly when the new value is 0. The skip-on-nonzero variant asserts it exactly when the new value is not 0.
- R7: `cycles_o` and `pc_step_o` are both 1 with no skip, 2 with a skip over a one-word instruction, and 3 with a skip over a two-word instruction. `done_o` pulses for one clock, 4 × `cycles_o` clocks after the accepting edge.
- R8: Any other opcode sets `illegal_o` and leaves memory and W unchanged. It reports no skip and one cycle.
- R9: While an instruction is in progress, `ready_o` is low and both start strobes and load writes are ignored.
- R10: After reset, `ready_o` is 1, `done_o` is 0, `skip_o` is 0 and W is 0.
- R11: `next_dword_i` has no effect when no skip is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock (four per instruction cycle) |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken while ready |
| instr_i | input | 16 | Instruction word |
| bank_i | input | 4 | Bank select value |
| next_dword_i | input | 1 | The already-fetched next instruction is two words long |
| ld_en_i | input | 1 | Load a memory byte (only while ready) |
| ld_addr_i | input | 12 | Load address |
| ld_data_i | input | 8 | Load data |
| peek_addr_i | input | 12 | Peek read address |
| ready_o | output | 1 | Idle, can accept an instruction |
| done_o | output | 1 | One-clock completion pulse |
| skip_o | output | 1 | Skip request of the last instruction |
| cycles_o | output | 2 | Instruction cycles used |
| pc_step_o | output | 2 | Program-counter advance in words |
| illegal_o | output | 1 | Last opcode was not recognised |
| w_o | output | 8 | Working register |
| peek_data_o | output | 8 | Memory byte at peek address |

## Verification
Two things happen in the same write phase: the wrapped result is stored, and the skip decision is taken from that same value. The bench triggers this by incrementing 8'hFF, both in place and into W, under each variant. It then checks the stored zero through the peek port, and checks the skip flag and the cycle count at `done_o`. It also checks that `done_o` arrives after the expected 4, 8 or 12 clocks. A start strobe is also sent in the middle of an instruction; the bench checks that its target byte stays unchanged and that no extra completion appears.

// File: rtl/incskip_pkg.sv
package incskip_pkg;
   localparam int INSTR_W = 16;
   localparam int FILE_W  = 8;
   localparam int OPC_W   = 6;

   localparam logic [OPC_W-1:0] OPC_INC_SKZ  = 6'b001111;
   localparam logic [OPC_W-1:0] OPC_INC_SKNZ = 6'b010010;

   typedef enum logic [1:0] {
      OPK_NONE  = 2'd0,
      OPK_SKZ   = 2'd1,
      OPK_SKNZ  = 2'd2
   } opk_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_EXEC  = 2'd1,
      ST_FLUSH = 2'd2
   } seq_st_t;
endpackage

// File: rtl/incskip_decode.sv
module incskip_decode
   import incskip_pkg::*;
#(
   parameter int BANK_W      = 4,
   parameter bit SPLIT_ACCESS = 1'b1,
   localparam int AW         = BANK_W + FILE_W
) (
   input  logic [INSTR_W-1:0] instr,
   input  logic [BANK_W-1:0]  bank,
   output opk_t               kind,
   output logic               to_file,
   output logic [AW-1:0]      addr
);
   localparam logic [OPC_W-1:0] OPC_TAB [2] = '{OPC_INC_SKZ, OPC_INC_SKNZ};

   logic [OPC_W-1:0]  opc;
   logic [FILE_W-1:0] fa;
   logic              banked;
   logic [1:0]        hit;
   logic [AW-1:0]     acc_addr;

   assign opc     = instr[15:10];
   assign to_file = instr[9];
   assign banked  = instr[8];
   assign fa      = instr[7:0];

   for (genvar g = 0; g < 2; g++) begin : g_match
      assign hit[g] = (opc == OPC_TAB[g]);
   end

   always_comb begin
      if (hit[0])      kind = OPK_SKZ;
      else if (hit[1]) kind = OPK_SKNZ;
      else             kind = OPK_NONE;
   end

   if (SPLIT_ACCESS) begin : g_split
      assign acc_addr = fa[FILE_W-1] ? {{BANK_W{1'b1}}, fa} : {{BANK_W{1'b0}}, fa};
   end else begin : g_flat
      assign acc_addr = {{BANK_W{1'b0}}, fa};
   end

   assign addr = banked ? {bank, fa} : acc_addr;
endmodule

// File: rtl/incskip_regfile.sv
module incskip_regfile
   import incskip_pkg::*;
#(
   parameter int BANK_W = 4,
   localparam int AW    = BANK_W + FILE_W,
   localparam int DEPTH = 1 << AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [AW-1:0]     ld_addr,
   input  logic [FILE_W-1:0] ld_data,
   input  logic              mem_we,
   input  logic [AW-1:0]     rw_addr,
   input  logic [FILE_W-1:0] wdata,
   input  logic              w_we,
   output logic [FILE_W-1:0] rdata,
   input  logic [AW-1:0]     peek_addr,
   output logic [FILE_W-1:0] peek_data,
   output logic [FILE_W-1:0] w_q
);
   logic [FILE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (mem_we)     mem[rw_addr] <= wdata;
      else if (ld_en) mem[ld_addr] <= ld_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    w_q <= '0;
      else if (w_we) w_q <= wdata;
   end

   assign rdata     = mem[rw_addr];
   assign peek_data = mem[peek_addr];

   AST_W_ONLY_ON_WE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(w_q) |-> $past(w_we)) else $error("W changed without write"); // R3
endmodule

// File: rtl/incskip_seq.sv
module incskip_seq
   import incskip_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       skip_now,
   input  logic       dword,
   output logic       ready,
   output logic       accept,
   output logic       ph_read,
   output logic       ph_proc,
   output logic       ph_write,
   output logic       done,
   output logic [1:0] cycles
);
   seq_st_t    st;
   logic [1:0] phase;
   logic [1:0] flush_left;

   assign ready    = (st == ST_IDLE);
   assign accept   = start && ready;
   assign ph_read  = (st == ST_EXEC) && (phase == 2'd1);
   assign ph_proc  = (st == ST_EXEC) && (phase == 2'd2);
   assign ph_write = (st == ST_EXEC) && (phase == 2'd3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         phase      <= '0;
         flush_left <= '0;
         done       <= 1'b0;
         cycles     <= '0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  st     <= ST_EXEC;
                  phase  <= '0;
                  cycles <= 2'd1;
               end
            end
            ST_EXEC: begin
               phase <= phase + 2'd1;
               if (phase == 2'd3) begin
                  if (skip_now) begin
                     st         <= ST_FLUSH;
                     flush_left <= dword ? 2'd2 : 2'd1;
                  end else begin
                     st   <= ST_IDLE;
                     done <= 1'b1;
                  end
               end
            end
            ST_FLUSH: begin
               phase <= phase + 2'd1;
               if (phase == 2'd3) begin
                  cycles <= cycles + 2'd1;
                  if (flush_left == 2'd1) begin
                     st   <= ST_IDLE;
                     done <= 1'b1;
                  end else begin
                     flush_left <= flush_left - 2'd1;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ready) else $error("done while busy"); // R9
endmodule

// File: rtl/incskip_exec.sv
module incskip_exec
   import incskip_pkg::*;
#(
   parameter int BANK_W       = 4,
   parameter bit SPLIT_ACCESS = 1'b1,
   localparam int AW          = BANK_W + FILE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [INSTR_W-1:0] instr_i,
   input  logic [BANK_W-1:0]  bank_i,
   input  logic               next_dword_i,
   input  logic               ld_en_i,
   input  logic [AW-1:0]      ld_addr_i,
   input  logic [FILE_W-1:0]  ld_data_i,
   input  logic [AW-1:0]      peek_addr_i,
   output logic               ready_o,
   output logic               done_o,
   output logic               skip_o,
   output logic [1:0]         cycles_o,
   output logic [1:0]         pc_step_o,
   output logic               illegal_o,
   output logic [FILE_W-1:0]  w_o,
   output logic [FILE_W-1:0]  peek_data_o
);
   if (BANK_W < 1 || BANK_W > 4) begin : g_bad_bank
      $error("BANK_W must be 1..4");
   end

   logic [INSTR_W-1:0] ir_q;
   logic [BANK_W-1:0]  bank_q;
   logic               dword_q;
   opk_t               kind;
   logic               to_file;
   logic [AW-1:0]      addr;
   logic [FILE_W-1:0]  rdata, opnd_q, sum_q;
   logic               accept, ph_read, ph_proc, ph_write;
   logic               skip_now, legal, mem_we, w_we;
   logic               skip_q, illegal_q;
   logic [1:0]         pc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ir_q    <= '0;
         bank_q  <= '0;
         dword_q <= 1'b0;
      end else if (accept) begin
         ir_q    <= instr_i;
         bank_q  <= bank_i;
         dword_q <= next_dword_i;
      end
   end

   incskip_decode #(.BANK_W(BANK_W), .SPLIT_ACCESS(SPLIT_ACCESS)) u_dec (
      .instr(ir_q), .bank(bank_q), .kind(kind), .to_file(to_file), .addr(addr)
   );

   assign legal    = (kind != OPK_NONE);
   assign skip_now = ((kind == OPK_SKZ)  && (sum_q == '0)) ||
                     ((kind == OPK_SKNZ) && (sum_q != '0));
   assign mem_we   = ph_write && legal && to_file;
   assign w_we     = ph_write && legal && !to_file;

   incskip_regfile #(.BANK_W(BANK_W)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .ld_en(ld_en_i && ready_o), .ld_addr(ld_addr_i), .ld_data(ld_data_i),
      .mem_we(mem_we), .rw_addr(addr), .wdata(sum_q), .w_we(w_we),
      .rdata(rdata), .peek_addr(peek_addr_i), .peek_data(peek_data_o), .w_q(w_o)
   );

   incskip_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start(start_i), .skip_now(skip_now),
      .dword(dword_q), .ready(ready_o), .accept(accept), .ph_read(ph_read),
      .ph_proc(ph_proc), .ph_write(ph_write), .done(done_o), .cycles(cycles_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opnd_q    <= '0;
         sum_q     <= '0;
         skip_q    <= 1'b0;
         illegal_q <= 1'b0;
         pc_q      <= '0;
      end else begin
         if (ph_read) opnd_q <= rdata;
         if (ph_proc) sum_q  <= opnd_q + 8'd1;
         if (ph_write) begin
            skip_q    <= skip_now;
            illegal_q <= !legal;
            pc_q      <= skip_now ? (dword_q ? 2'd3 : 2'd2) : 2'd1;
         end
      end
   end

   assign skip_o    = skip_q;
   assign illegal_o = illegal_q;
   assign pc_step_o = pc_q;

   AST_PC_MATCHES_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (pc_step_o == cycles_o)) else $error("pc step vs cycles"); // R7
   AST_SKIP_COSTS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && skip_o) |-> (cycles_o >= 2'd2)) else $error("skip too short"); // R7
   AST_NOSKIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !skip_o) |-> (cycles_o == 2'd1)) else $error("no-skip long"); // R11
   AST_ILLEGAL_NOSKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && illegal_o) |-> !skip_o) else $error("illegal skipped"); // R8
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && start_i) |=> !ready_o) else $error("ready after start"); // R9
endmodule

// File: tb/incskip_exec_bench.sv
module incskip_exec_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   typedef struct {
      logic       skip;
      logic [1:0] cyc;
      logic       ill;
      int         t0;
      string      tag;
   } exp_t;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        start_i = 1'b0, next_dword_i = 1'b0, ld_en_i = 1'b0;
   logic [15:0] instr_i = '0;
   logic [3:0]  bank_i = '0;
   logic [11:0] ld_addr_i = '0, peek_addr_i = '0;
   logic [7:0]  ld_data_i = '0;
   logic        ready_o, done_o, skip_o, illegal_o;
   logic [1:0]  cycles_o, pc_step_o;
   logic [7:0]  w_o, peek_data_o;

   int   total = 0, bad = 0, cyc = 0;
   exp_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   incskip_exec u_incskip_exec (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
      .bank_i(bank_i), .next_dword_i(next_dword_i), .ld_en_i(ld_en_i),
      .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i), .peek_addr_i(peek_addr_i),
      .ready_o(ready_o), .done_o(done_o), .skip_o(skip_o), .cycles_o(cycles_o),
      .pc_step_o(pc_step_o), .illegal_o(illegal_o), .w_o(w_o),
      .peek_data_o(peek_data_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] enc(input logic z, input logic d, input logic a,
                                       input logic [7:0] f);
      return {(z ? 6'b001111 : 6'b010010), d, a, f};
   endfunction

   task automatic load(input logic [11:0] a, input logic [7:0] v);
      @(negedge clk);
      ld_en_i = 1'b1; ld_addr_i = a; ld_data_i = v;
      @(negedge clk);
      ld_en_i = 1'b0;
   endtask

   task automatic peek(input string tag, input logic [11:0] a, input logic [7:0] exp);
      peek_addr_i = a;
      #1;
      check(tag, peek_data_o, exp);
   endtask

   // driver: start one instruction, push expectation, wait for the monitor
   task automatic run(input logic [15:0] ins, input logic [3:0] bk, input logic dw,
                      input logic e_skip, input logic [1:0] e_cyc, input logic e_ill,
                      input string tag);
      exp_t it;
      @(negedge clk);
      instr_i = ins; bank_i = bk; next_dword_i = dw; start_i = 1'b1;
      it.skip = e_skip; it.cyc = e_cyc; it.ill = e_ill; it.t0 = cyc + 1; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
      start_i = 1'b0;
      while (sb_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (sb_q.size() == 0) begin
            check("R9 unexpected done", 1, 0);
         end else begin
            exp_t it;
            it = sb_q.pop_front();
            check({it.tag, " R6 skip"}, skip_o, it.skip);
            check({it.tag, " R7 cycles"}, cycles_o, it.cyc);
            check({it.tag, " R7 pc_step"}, pc_step_o, it.cyc);
            check({it.tag, " R8 illegal"}, illegal_o, it.ill);
            check({it.tag, " R7 latency"}, cyc - it.t0, 4 * int'(it.cyc));
         end
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      check("watchdog", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R10 ready", ready_o, 1);
      check("R10 done", done_o, 0);
      check("R10 skip", skip_o, 0);
      check("R10 W", w_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: access bank low half, bank input ignored
      load(12'h010, 8'h05);
      load(12'h310, 8'h44);
      run(enc(1, 1, 0, 8'h10), 4'h3, 1'b0, 0, 2'd1, 0, "R4_lo");
      peek("R2 inc", 12'h010, 8'h06);
      peek("R4 bank ignored", 12'h310, 8'h44);

      // R2/R6/R4: wrap to zero in SFR bank, skip one-word
      load(12'hF85, 8'hFF);
      run(enc(1, 1, 0, 8'h85), 4'h2, 1'b0, 1, 2'd2, 0, "R6_z1");
      peek("R2 wrap", 12'hF85, 8'h00);
      check("R3 W untouched", w_o, 8'h00);

      // R7: skip over a two-word instruction
      load(12'hF85, 8'hFF);
      run(enc(1, 1, 0, 8'h85), 4'h0, 1'b1, 1, 2'd3, 0, "R7_dw");

      // R5/R3/R6: banked, to W, nonzero skip, two-word
      load(12'h520, 8'h7F);
      run(enc(0, 0, 1, 8'h20), 4'h5, 1'b1, 1, 2'd3, 0, "R5_nz");
      check("R3 W gets result", w_o, 8'h80);
      peek("R3 mem unchanged", 12'h520, 8'h7F);

      // R11: nonzero variant hits zero, no skip, dword ignored
      load(12'h521, 8'hFF);
      run(enc(0, 1, 1, 8'h21), 4'h5, 1'b1, 0, 2'd1, 0, "R11_noskip");
      peek("R2 wrap banked", 12'h521, 8'h00);

      // R6: zero variant, nonzero result into W
      load(12'h522, 8'h10);
      run(enc(1, 0, 1, 8'h22), 4'h5, 1'b1, 0, 2'd1, 0, "R6_zn");
      check("R3 W 11", w_o, 8'h11);

      // R6: zero variant wrap into W (both write and skip)
      load(12'h523, 8'hFF);
      run(enc(1, 0, 1, 8'h23), 4'h5, 1'b0, 1, 2'd2, 0, "R6_zw");
      check("R3 W zero", w_o, 8'h00);
      peek("R3 mem kept", 12'h523, 8'hFF);

      // R8: illegal opcode
      load(12'h030, 8'h20);
      run({6'b001010, 1'b1, 1'b0, 8'h30}, 4'h0, 1'b1, 0, 2'd1, 1, "R8_ill");
      peek("R8 mem unchanged", 12'h030, 8'h20);
      check("R8 W unchanged", w_o, 8'h00);

      // R1: neighbouring opcode 001110 not recognised
      run({6'b001110, 1'b1, 1'b0, 8'h30}, 4'h0, 1'b0, 0, 2'd1, 1, "R1_near");
      peek("R1 mem unchanged", 12'h030, 8'h20);

      // R9: start and load while busy are ignored
      load(12'h040, 8'h01);
      load(12'h050, 8'h09);
      begin
         exp_t it;
         @(negedge clk);
         instr_i = enc(1, 1, 0, 8'h40); bank_i = 0; next_dword_i = 0; start_i = 1'b1;
         it.skip = 0; it.cyc = 2'd1; it.ill = 0; it.t0 = cyc + 1; it.tag = "R9_busy";
         sb_q.push_back(it);
         @(negedge clk);
         check("R9 ready low", ready_o, 0);
         instr_i = enc(1, 1, 0, 8'h50);
         ld_en_i = 1'b1; ld_addr_i = 12'h050; ld_data_i = 8'hAA;
         @(negedge clk);
         start_i = 1'b0; ld_en_i = 1'b0;
         while (sb_q.size() != 0) @(negedge clk);
         repeat (8) @(negedge clk);
      end
      peek("R9 executed", 12'h040, 8'h02);
      peek("R9 second ignored", 12'h050, 8'h09);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule